// File: doc/BRIEF.md
# 8-bit ALU with Flag Update

This block is the arithmetic and logic stage of a small 8-bit processor core. On each cycle an operation code arrives together with two 8-bit operands. The second operand can be a register value or an immediate. The block returns the 8-bit result at once, through combinational logic. It also returns a signal saying whether that result is meant to be written back, and a mask naming the status flags that the operation defines. The status byte is held inside the block. On the clock edge it takes the new value only in the flags that the mask enables, so every operation leaves the flags outside its own set unchanged.

The carry-in for the with-carry forms, the shifts and the rotate comes from the held carry flag. A 16-bit word add or subtract runs as two passes: the low byte first, then the high byte. The carry and zero flags link the two passes. Decoding instructions, the register file and memory are handled elsewhere.

Top module: `alu8_flags`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `sreg` becomes 0x00.
- R2: The `sreg` bit positions are C=0, Z=1, N=2, V=3, S=4 and H=5, and bits 7:6 always read 0. On a valid cycle, each flag whose `flag_we` bit is 1 takes its new value, and every other flag keeps its value.
- R3: The `op` codes are 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 CMP, 5 CPC, 6 AND, 7 OR, 8 XOR, 9 SETB, 10 CLRB, 11 COM, 12 NEG, 13 INC, 14 DEC, 15 LSL, 16 LSR, 17 ROL, 18 WADDL, 19 WADDH, 20 WSUBL and 21 WSUBH. ADD computes a+b and ADC computes a+b+C. Both write H, S, V, N, Z and C (mask 0x3F). C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow.
- R4: SUB computes a-b and SBC computes a-b-C, with mask 0x3F. C is the borrow out of bit 7, H is the borrow into bit 4, and V is signed overflow.
- R5: For SBC, CPC and WSUBH, Z becomes 1 only if the result is zero and Z was already 1. Otherwise Z becomes 0.
- R6: CMP and CPC set the flags exactly as SUB and SBC would, but `res_wr` is 0.
- R7: AND and OR compute a&b and a|b. XOR computes a^b. SETB computes a|b, and CLRB computes a&(0xFF-b). All five use mask 0x1E and force V to 0, so C and H are preserved.
- R8: INC computes a+1 and DEC computes a-1, with mask 0x1E. V is set only for INC of 0x7F and for DEC of 0x80.
- R9: COM computes 0xFF-a and sets C=1 and V=0, with mask 0x1F. NEG computes 0x00-a with mask 0x3F. It sets C if a is nonzero, H if a[3:0] is nonzero, and V if a equals 0x80.
- R10: LSL shifts left and fills bit 0 with 0. LSR shifts right and fills bit 7 with 0. ROL shifts left, taking the old C into bit 0. Each puts the bit shifted out into C and sets V=N^C, with mask 0x1F.
- R11: A word operation is a low pass followed by a high pass. WADDL and WSUBL add or subtract the low bytes, updating only Z and C (mask 0x03). WADDH and WSUBH add or subtract the high bytes with C, using mask 0x1F and a chained Z. The resulting flags describe the full 16-bit result.
- R12: S always equals N^V in `sreg`.
- R13: When `op_valid` is low, `res_wr` and `flag_we` are 0 and `sreg` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op | input | 5 | Operation code (see R3) |
| opa | input | 8 | First operand (destination register value) |
| opb | input | 8 | Second operand (register or immediate) |
| res | output | 8 | Result, combinational |
| res_wr | output | 1 | Result should be written back |
| flag_we | output | 8 | Flags this operation updates |
| sreg | output | 8 | Held status flags |

## Verification
Directed operands are chosen to hit each flag boundary once. These are a nibble carry such as 0x0F+0x01, a signed wrap such as 0x7F+0x01, a full carry to zero, and a borrow out of bit 4. They separate H from C and V from C. Compare chains are run twice, once with an equal low byte and once with an unequal one, which shows whether Z is really chained or simply recomputed. A logic operation follows a carry-setting add, and a rotate runs with C set, which exposes any carry leak. After these, a long sequence of random operations, with occasional idle cycles, is checked against a behavioural model on every cycle.

// File: rtl/alu8_pkg.sv
// Package: shared widths, flag positions, op codes and decoded control
// word for the 8-bit ALU. Assumes flag positions are fixed by R2.
package alu8_pkg;
    localparam int DW = 8;           // datapath width
    localparam int FW = 8;           // status byte width
    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FN = 2;
    localparam int FV = 3;
    localparam int FS = 4;
    localparam int FH = 5;

    // Per-class flag masks
    localparam logic [FW-1:0] M_FULL  = 8'h3F;  // H S V N Z C
    localparam logic [FW-1:0] M_LOGIC = 8'h1E;  // S V N Z
    localparam logic [FW-1:0] M_SHIFT = 8'h1F;  // S V N Z C
    localparam logic [FW-1:0] M_WLO   = 8'h03;  // Z C

    typedef enum logic [4:0] {
        OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC,
        OP_AND, OP_OR, OP_XOR, OP_SETB, OP_CLRB, OP_COM,
        OP_NEG, OP_INC, OP_DEC, OP_LSL, OP_LSR, OP_ROL,
        OP_WADDL, OP_WADDH, OP_WSUBL, OP_WSUBH
    } alu_op_e;

    typedef struct packed {
        logic          logic_path;  // result from logic/shift unit
        logic          sub;         // adder subtracts
        logic          use_c;       // carry-in from held C
        logic          neg_form;    // adder computes 0 - a
        logic          one_form;    // adder uses constant 1 as b
        logic          zchain;      // Z only stays set
        logic          wr;          // result written back
        logic [FW-1:0] mask;        // flags updated
    } alu_ctl_t;
endpackage

// File: rtl/alu8_addsub.sv
// Adder/subtractor: computes a+b+cin or a-b-cin and reports carry/borrow
// out of the top bit, carry/borrow at the nibble boundary and signed
// overflow. Assumes W >= 5.
module alu8_addsub #(
    parameter int W = alu8_pkg::DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         cout,
    output logic         hc,
    output logic         ov
);
    localparam int NB = 4;

    logic [W:0]  full;
    logic [NB:0] nib;

    // Wide and nibble sums, plus overflow from operand/result signs
    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - (W+1)'(cin);
            nib  = {1'b0, a[NB-1:0]} - {1'b0, b[NB-1:0]} - (NB+1)'(cin);
            ov   = (a[W-1] != b[W-1]) && (full[W-1] != a[W-1]);
        end else begin
            full = {1'b0, a} + {1'b0, b} + (W+1)'(cin);
            nib  = {1'b0, a[NB-1:0]} + {1'b0, b[NB-1:0]} + (NB+1)'(cin);
            ov   = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
        end
        r    = full[W-1:0];
        cout = full[W];
        hc   = nib[NB];
    end
endmodule

// File: rtl/alu8_logic.sv
// Logic and shift unit: bitwise ops, bit set/clear masks, one's
// complement and single-bit shifts/rotate. Provides carry and overflow
// for the ops that define them; others report V=0.
module alu8_logic #(
    parameter int W = alu8_pkg::DW
) (
    input  alu8_pkg::alu_op_e op,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic              cin,
    output logic [W-1:0]      r,
    output logic              cout,
    output logic              ov
);
    import alu8_pkg::*;

    // Select the result and the bit shifted out
    always_comb begin
        r    = a;
        cout = 1'b0;
        ov   = 1'b0;
        case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_SETB: r = a | b;
            OP_CLRB: r = a & ~b;
            OP_COM:  begin r = ~a; cout = 1'b1; end
            OP_LSL:  begin r = {a[W-2:0], 1'b0}; cout = a[W-1]; ov = a[W-2] ^ a[W-1]; end
            OP_LSR:  begin r = {1'b0, a[W-1:1]}; cout = a[0];   ov = a[0]; end
            OP_ROL:  begin r = {a[W-2:0], cin};  cout = a[W-1]; ov = a[W-2] ^ a[W-1]; end
            default: r = a;
        endcase
    end
endmodule

// File: rtl/alu8_decode.sv
// Decoder: maps an op code to the control word (datapath choice, carry
// source, Z chaining, write-back and flag mask). Unknown codes decode
// to a no-op with an empty mask.
module alu8_decode (
    input  alu8_pkg::alu_op_e op,
    output alu8_pkg::alu_ctl_t ctl
);
    import alu8_pkg::*;

    // Per-op control table
    always_comb begin
        ctl = '{logic_path: 1'b0, sub: 1'b0, use_c: 1'b0, neg_form: 1'b0,
                one_form: 1'b0, zchain: 1'b0, wr: 1'b1, mask: M_FULL};
        case (op)
            OP_ADD:   ;
            OP_ADC:   ctl.use_c = 1'b1;
            OP_SUB:   ctl.sub = 1'b1;
            OP_SBC:   begin ctl.sub = 1'b1; ctl.use_c = 1'b1; ctl.zchain = 1'b1; end
            OP_CMP:   begin ctl.sub = 1'b1; ctl.wr = 1'b0; end
            OP_CPC:   begin ctl.sub = 1'b1; ctl.use_c = 1'b1; ctl.zchain = 1'b1; ctl.wr = 1'b0; end
            OP_AND, OP_OR, OP_XOR, OP_SETB, OP_CLRB:
                      begin ctl.logic_path = 1'b1; ctl.mask = M_LOGIC; end
            OP_COM:   begin ctl.logic_path = 1'b1; ctl.mask = M_SHIFT; end
            OP_NEG:   begin ctl.sub = 1'b1; ctl.neg_form = 1'b1; end
            OP_INC:   begin ctl.one_form = 1'b1; ctl.mask = M_LOGIC; end
            OP_DEC:   begin ctl.one_form = 1'b1; ctl.sub = 1'b1; ctl.mask = M_LOGIC; end
            OP_LSL, OP_LSR:
                      begin ctl.logic_path = 1'b1; ctl.mask = M_SHIFT; end
            OP_ROL:   begin ctl.logic_path = 1'b1; ctl.use_c = 1'b1; ctl.mask = M_SHIFT; end
            OP_WADDL: ctl.mask = M_WLO;
            OP_WADDH: begin ctl.use_c = 1'b1; ctl.zchain = 1'b1; ctl.mask = M_SHIFT; end
            OP_WSUBL: begin ctl.sub = 1'b1; ctl.mask = M_WLO; end
            OP_WSUBH: begin ctl.sub = 1'b1; ctl.use_c = 1'b1; ctl.zchain = 1'b1; ctl.mask = M_SHIFT; end
            default:  begin ctl.wr = 1'b0; ctl.mask = '0; end
        endcase
    end
endmodule

// File: rtl/alu8_flags.sv
// Top: 8-bit ALU with masked status update. The result is combinational
// from op, operands and held flags; the status byte updates on the clock
// edge only in the flags the op defines. Synchronous active-low reset.
module alu8_flags #(
    parameter int W = alu8_pkg::DW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic [4:0]             op,
    input  logic [W-1:0]           opa,
    input  logic [W-1:0]           opb,
    output logic [W-1:0]           res,
    output logic                   res_wr,
    output logic [alu8_pkg::FW-1:0] flag_we,
    output logic [alu8_pkg::FW-1:0] sreg
);
    import alu8_pkg::*;

    alu_op_e      op_e;
    alu_ctl_t     ctl;
    logic [W-1:0] as_a, as_b, as_r, lg_r;
    logic         as_c, as_h, as_v, lg_c, lg_v, cin;
    logic         f_c, f_z, f_n, f_v;
    logic [FW-1:0] f_new;

    assign op_e = alu_op_e'(op);

    alu8_decode i_dec (.op(op_e), .ctl(ctl));

    // Adder operand selection for negate and increment/decrement forms
    always_comb begin
        cin  = ctl.use_c & sreg[FC];
        as_a = ctl.neg_form ? '0 : opa;
        as_b = ctl.neg_form ? opa : (ctl.one_form ? W'(1) : opb);
    end

    alu8_addsub #(.W(W)) i_as (
        .a(as_a), .b(as_b), .cin(cin), .sub(ctl.sub),
        .r(as_r), .cout(as_c), .hc(as_h), .ov(as_v)
    );

    alu8_logic #(.W(W)) i_lg (
        .op(op_e), .a(opa), .b(opb), .cin(cin),
        .r(lg_r), .cout(lg_c), .ov(lg_v)
    );

    // Result mux and new flag values
    always_comb begin
        res   = ctl.logic_path ? lg_r : as_r;
        f_c   = ctl.logic_path ? lg_c : as_c;
        f_v   = ctl.logic_path ? lg_v : as_v;
        f_n   = res[W-1];
        f_z   = (res == '0) && (!ctl.zchain || sreg[FZ]);
        f_new = '0;
        f_new[FC] = f_c;
        f_new[FZ] = f_z;
        f_new[FN] = f_n;
        f_new[FV] = f_v;
        f_new[FS] = f_n ^ f_v;
        f_new[FH] = as_h;
        flag_we = op_valid ? ctl.mask : '0;
        res_wr  = op_valid & ctl.wr;
    end

    // Status byte: merge new values under the write mask
    always_ff @(posedge clk) begin
        if (!rst_n)
            sreg <= '0;
        else
            sreg <= (sreg & ~flag_we) | (f_new & flag_we);
    end
endmodule

// File: rtl/alu8_flags_chk.sv
// Checker: temporal properties on the ALU's ports; bound to alu8_flags.
module alu8_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [4:0] op,
    input logic       res_wr,
    input logic [7:0] flag_we,
    input logic [7:0] sreg
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sreg == 8'h00));

    // R2
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (((sreg ^ $past(sreg)) & ~$past(flag_we)) == 8'h00));

    // R2
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sreg[7:6] == 2'b00);

    // R12
    sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sreg[4] == (sreg[2] ^ sreg[3]));

    // R6
    cmp_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == 5'd4 || op == 5'd5)) |-> !res_wr);

    // R7
    logic_keep_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op >= 5'd6 && op <= 5'd10) |-> (flag_we[0] == 1'b0 && flag_we[5] == 1'b0));

    // R13
    idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(sreg));

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (flag_we == 8'h00 && !res_wr));
endmodule

bind alu8_flags alu8_flags_chk i_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
    .res_wr(res_wr), .flag_we(flag_we), .sreg(sreg)
);

// File: tb/test_alu8_flags.sv
module test_alu8_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] opa = '0, opb = '0;
    logic [7:0] res, flag_we, sreg;
    logic       res_wr;

    int n_chk = 0, n_fail = 0;
    int msreg = 0;
    bit done = 0;

    always #5 clk = ~clk;

    alu8_flags i_alu8_flags (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
        .opa(opa), .opb(opb), .res(res), .res_wr(res_wr),
        .flag_we(flag_we), .sreg(sreg)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: result, new flags, mask, write-back
    task automatic model(input int oc, input int a, input int b,
                         output int r, output int f, output int m, output int w);
        int c, z, s, fc, fz, fn, fv, fh, ci;
        bit chain;
        c = msreg & 1; z = (msreg >> 1) & 1;
        fc = 0; fv = 0; fh = 0; chain = 0; w = 1; m = 'h3F; r = 0;
        case (oc)
            0, 1, 18, 19: begin
                ci = (oc == 1 || oc == 19) ? c : 0;
                s = a + b + ci; r = s & 255; fc = (s > 255);
                fh = (((a & 15) + (b & 15) + ci) > 15);
                fv = (((a ^ r) & (b ^ r) & 128) != 0);
                chain = (oc == 19);
                m = (oc == 18) ? 'h03 : (oc == 19) ? 'h1F : 'h3F;
            end
            2, 3, 4, 5, 20, 21: begin
                ci = (oc == 3 || oc == 5 || oc == 21) ? c : 0;
                s = a - b - ci; r = s & 255; fc = (s < 0);
                fh = (((a & 15) - (b & 15) - ci) < 0);
                fv = (((a ^ b) & (a ^ r) & 128) != 0);
                chain = (oc == 3 || oc == 5 || oc == 21);
                w = (oc == 4 || oc == 5) ? 0 : 1;
                m = (oc == 20) ? 'h03 : (oc == 21) ? 'h1F : 'h3F;
            end
            6, 7, 8, 9, 10: begin
                r = (oc == 6) ? (a & b) : (oc == 8) ? (a ^ b) :
                    (oc == 10) ? (a & (255 - b)) : (a | b);
                m = 'h1E;
            end
            11: begin r = 255 - a; fc = 1; m = 'h1F; end
            12: begin r = (256 - a) & 255; fc = (a != 0); fh = ((a & 15) != 0); fv = (a == 128); end
            13: begin r = (a + 1) & 255; fv = (a == 127); m = 'h1E; end
            14: begin r = (a + 255) & 255; fv = (a == 128); m = 'h1E; end
            15, 16, 17: begin
                if (oc == 16) begin r = a >> 1; fc = a & 1; end
                else begin r = ((a << 1) & 255) | ((oc == 17) ? c : 0); fc = a >> 7; end
                fv = ((r >> 7) & 1) ^ fc; m = 'h1F;
            end
            default: begin w = 0; m = 0; r = a; end
        endcase
        fz = (r == 0) && (!chain || z);
        fn = (r >> 7) & 1;
        f = fc | (fz << 1) | (fn << 2) | (fv << 3) | ((fn ^ fv) << 4) | (fh << 5);
    endtask

    // One cycle: drive at falling edge, check comb outputs, then sreg
    task automatic run(string tag, int oc, int a, int b, bit v = 1);
        int r, f, m, w;
        @(negedge clk);
        op_valid = v; op = 5'(oc); opa = 8'(a); opb = 8'(b);
        #2;
        model(oc, a, b, r, f, m, w);
        if (!v) begin m = 0; w = 0; end
        if (v && w) check({tag, " res"}, int'(res), r);
        check({tag, " res_wr"}, int'(res_wr), w);
        check({tag, " flag_we"}, int'(flag_we), m);
        @(posedge clk); #1;
        msreg = (msreg & ~m & 255) | (f & m);
        check({tag, " sreg R2"}, int'(sreg), msreg);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset sreg", int'(sreg), 0);
        @(negedge clk); rst_n = 1'b1;
        // R3 add boundaries
        run("R3 add nibble", 0, 'h0F, 'h01);
        run("R3 add overflow", 0, 'h7F, 'h01);
        run("R3 add carry zero", 0, 'hFF, 'h01);
        run("R3 adc with C", 1, 'h10, 'h20);
        // R4 subtract
        run("R4 sub half borrow", 2, 'h10, 'h01);
        run("R4 sub borrow", 2, 'h00, 'h01);
        run("R4 sbc with C", 3, 'h50, 'h10);
        // R5 R6 compare chains
        run("R6 cmp equal", 4, 'h33, 'h33);
        run("R5 cpc equal keeps Z", 5, 'h12, 'h12);
        run("R6 cmp unequal", 4, 'h34, 'h33);
        run("R5 cpc zero but Z clear", 5, 'h12, 'h12);
        // R7 logic keeps C
        run("R3 set C", 0, 'hFF, 'h02);
        run("R7 and", 6, 'hF0, 'h3C);
        run("R7 or", 7, 'h80, 'h01);
        run("R7 xor", 8, 'hAA, 'hAA);
        run("R7 setb", 9, 'h01, 'h80);
        run("R7 clrb", 10, 'hFF, 'h0F);
        // R8 inc/dec
        run("R8 inc 7F", 13, 'h7F, 0);
        run("R8 dec 80", 14, 'h80, 0);
        run("R8 dec 00", 14, 'h00, 0);
        // R9 complements
        run("R9 com", 11, 'h5A, 0);
        run("R9 neg 0", 12, 'h00, 0);
        run("R9 neg 80", 12, 'h80, 0);
        run("R9 neg 01", 12, 'h01, 0);
        // R10 shifts
        run("R10 lsl", 15, 'h81, 0);
        run("R10 rol C=1", 17, 'h40, 0);
        run("R10 lsr", 16, 'h01, 0);
        // R11 word ops
        run("R11 wadd lo", 18, 'hFF, 'h01);
        run("R11 wadd hi", 19, 'h00, 'h00);
        run("R11 wsub lo", 20, 'h00, 'h01);
        run("R11 wsub hi", 21, 'h01, 'h00);
        run("R11 wadd lo zero", 18, 'h00, 'h00);
        run("R11 wadd hi zero", 19, 'h00, 'h00);
        // R13 idle
        run("R13 idle", 0, 'hFF, 'hFF, 0);
        // R12 and mixed random traffic
        for (int i = 0; i < 600; i++) begin
            int oc;
            oc = int'($urandom_range(21));
            run("R12 random", oc, int'($urandom_range(255)), int'($urandom_range(255)),
                ($urandom_range(9) != 0));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule